// File: doc/BRIEF.md
# Four-channel DMA grant arbiter

This block chooses which of four DMA channels owns the shared bus. Each channel raises a request line. When no grant is outstanding and arbitration is allowed, the arbiter picks one requester. The choice follows one of four rankings, selected by a 2-bit mode input. The winner receives a registered one-hot grant, and a one-cycle valid strobe marks the new decision. The grant stays with that channel until it withdraws its request. Only then does the arbiter return to its idle state and decide again.

Arbitration is allowed only while the global enable input is high and both blocking flags are low. The two blocking flags are an address-fault flag and a non-maskable-interrupt flag. Dropping the enable, or raising either flag, also takes away a grant that is currently held.

The controller has two named states:

- `ST_IDLE`: no grant is out.
- `ST_HOLD`: one channel owns the bus.

The transitions between them are:

- `ST_IDLE` to `ST_HOLD` (the grant transition): arbitration is allowed and at least one request is present.
- `ST_HOLD` to `ST_HOLD` (the keep transition): the owner still requests and arbitration is still allowed.
- `ST_HOLD` to `ST_IDLE` (the release transition): the owner drops its request, or arbitration is blocked.

All inputs are sampled at the rising clock edge. Grant and strobe change just after that edge.

Top module: `dma_grant_arbiter`

## Requirements
- R1: With mode code 2'b00 the ranking, from highest to lowest, is channel 0, 1, 2, 3.
- R2: With mode code 2'b01 the ranking, from highest to lowest, is channel 0, 2, 3, 1.
- R3: With mode code 2'b10 the ranking, from highest to lowest, is channel 2, 0, 1, 3.
- R4: Mode code 2'b11 selects rotating priority. After a channel g is granted in this mode, the ranking becomes g+1, g+2, g+3, g (modulo 4). A grant made in any other mode leaves the rotation unchanged.
- R5: The grant (bit i = channel i) is always one-hot or zero. A new grant goes only to a channel whose request was high at the deciding edge. The valid strobe is high for exactly the one cycle after that edge.
- R6: While the enable input is low, no grant is issued, and a held grant is cleared after the next edge.
- R7: While the address-fault flag or the interrupt flag is high, no grant is issued, and a held grant is cleared after the next edge.
- R8: A held grant stays unchanged while its channel keeps requesting and arbitration is allowed. This holds even if the mode input or other requests change.
- R9: When the owning channel drops its request, the grant clears after the next edge. A new grant appears no earlier than the edge after that.
- R10: After reset the grant and the strobe are zero, and the rotation starts with channel 0 ranked highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Channel request lines, bit i = channel i |
| prio_mode_i | input | 2 | Ranking select: 00, 01 and 10 are fixed orders; 11 is rotating |
| master_en_i | input | 1 | Global enable for all grants |
| addr_err_i | input | 1 | Address-fault flag; blocks grants while high |
| nmi_flag_i | input | 1 | Non-maskable-interrupt flag; blocks grants while high |
| grant_o | output | 4 | One-hot grant, bit i = channel i |
| grant_vld_o | output | 1 | One-cycle strobe marking a new grant |

## Verification
The bench drives all four requests together in each mode, so that each irregular ranking must resolve exactly as listed. A design with a swapped table entry would favour channel 1 over channel 2 in mode 01, or channel 0 over channel 2 in mode 10.

Rotation is followed through a full cycle of wins that wraps from channel 3 back to channel 0. It is also checked after grants made in fixed modes. A wrong update would repeat a channel, skip a channel, or rotate on fixed-mode wins.

The flags are raised during a held grant. This exposes a design that keeps the bus while blocked, or one that re-grants in the same cycle that the old owner releases.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int NCH = 4;
    localparam int CHW = $clog2(NCH);
    localparam int MW  = 2;

    typedef enum logic [MW-1:0] {
        MODE_FIX_A  = 2'b00,
        MODE_FIX_B  = 2'b01,
        MODE_FIX_C  = 2'b10,
        MODE_ROTATE = 2'b11
    } prio_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_e;

    // Channel placed at rank k (0 = highest) for a fixed mode.
    function automatic logic [CHW-1:0] fixed_rank(input logic [MW-1:0] mode,
                                                  input logic [CHW-1:0] k);
        logic [CHW-1:0] ord [NCH];
        unique case (mode)
            MODE_FIX_B: ord = '{2'd0, 2'd2, 2'd3, 2'd1};
            MODE_FIX_C: ord = '{2'd2, 2'd0, 2'd1, 2'd3};
            default:    ord = '{2'd0, 2'd1, 2'd2, 2'd3};
        endcase
        return ord[k];
    endfunction
endpackage

// File: rtl/arb_pick.sv
module arb_pick
    import dma_arb_pkg::*;
(
    input  logic [NCH-1:0] req,
    input  logic [MW-1:0]  mode,
    input  logic [CHW-1:0] ptr,
    output logic           found,
    output logic [CHW-1:0] idx,
    output logic [NCH-1:0] onehot
);
    logic [CHW-1:0] rank_ch [NCH];
    logic [NCH-1:0] hit;

    for (genvar k = 0; k < NCH; k++) begin : g_rank
        assign rank_ch[k] = (mode == MODE_ROTATE) ? CHW'(ptr + CHW'(k))
                                                  : fixed_rank(mode, CHW'(k));
        assign hit[k]     = req[rank_ch[k]];
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (hit[k]) begin
                found = 1'b1;
                idx   = rank_ch[k];
            end
        end
        onehot = found ? (NCH'(1) << idx) : '0;
    end

    always_comb begin
        // R5
        pick_req_chk: assert (!found || req[idx]);
        // R5
        pick_any_chk: assert (found == (|req));
    end
endmodule

// File: rtl/arb_rr_ptr.sv
module arb_rr_ptr
    import dma_arb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic [CHW-1:0] served,
    output logic [CHW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= CHW'(served + 1'b1);
    end

    // R4
    ptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/dma_grant_arbiter.sv
module dma_grant_arbiter
    import dma_arb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic [MW-1:0]  prio_mode_i,
    input  logic           master_en_i,
    input  logic           addr_err_i,
    input  logic           nmi_flag_i,
    output logic [NCH-1:0] grant_o,
    output logic           grant_vld_o
);
    arb_state_e     state_q, state_d;
    logic [NCH-1:0] grant_q;
    logic           vld_q;
    logic           clear_ok, keep, found, adv;
    logic [CHW-1:0] pick_idx, ptr;
    logic [NCH-1:0] pick_oh;

    assign clear_ok = master_en_i && !addr_err_i && !nmi_flag_i;
    assign keep     = |(req_i & grant_q);
    assign adv      = (state_q == ST_IDLE) && clear_ok && found &&
                      (prio_mode_i == MODE_ROTATE);

    arb_pick u_pick (
        .req    (req_i),
        .mode   (prio_mode_i),
        .ptr    (ptr),
        .found  (found),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    arb_rr_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .served (pick_idx),
        .ptr    (ptr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (clear_ok && found)   state_d = ST_HOLD;
            ST_HOLD: if (!clear_ok || !keep)  state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (clear_ok && found) begin
                        grant_q <= pick_oh;
                        vld_q   <= 1'b1;
                    end else begin
                        grant_q <= '0;
                    end
                end
                ST_HOLD: if (!clear_ok || !keep) grant_q <= '0;
                default: grant_q <= '0;
            endcase
        end
    end

    assign grant_o     = grant_q;
    assign grant_vld_o = vld_q;

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));
    // R5
    vld_has_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (grant_q != '0));
    // R5
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);
    // R5
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> |(grant_q & $past(req_i)));
    // R6
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en_i |=> (grant_q == '0));
    // R7
    error_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_err_i || nmi_flag_i) |=> (grant_q == '0));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_q != '0) && clear_ok && keep) |=> (grant_q == $past(grant_q)));
    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_q != '0) && !keep) |=> (grant_q == '0));
    // R9
    gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> ($past(grant_q) == '0));
endmodule

// File: tb/dma_grant_arbiter_tb.sv
`timescale 1ns/1ps
module dma_grant_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [1:0] md = '0;
    logic       en = 1'b0, ae = 1'b0, nm = 1'b0;
    logic [3:0] grant;
    logic       vld;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic       m_hold;
    logic [3:0] m_grant;
    logic [1:0] m_ptr;

    always #2 clk = ~clk;

    dma_grant_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .prio_mode_i(md),
        .master_en_i(en), .addr_err_i(ae), .nmi_flag_i(nm),
        .grant_o(grant), .grant_vld_o(vld)
    );

    function automatic int ch_at(input logic [1:0] mode, input logic [1:0] p, input int k);
        int fb [4] = '{0, 2, 3, 1};
        int fc [4] = '{2, 0, 1, 3};
        case (mode)
            2'b00:   return k;
            2'b01:   return fb[k];
            2'b10:   return fc[k];
            default: return (int'(p) + k) % 4;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: {vld,grant} got %b expected %b", tag, act, exp);
        end
    endtask

    // Drive inputs at a falling edge, predict, then compare at the next falling edge.
    task automatic step(input logic [3:0] r, input logic [1:0] m, input logic e,
                        input logic a, input logic n);
        logic ok;
        logic [3:0] eg;
        logic ev, nh;
        logic [1:0] np;
        string tag;
        req = r; md = m; en = e; ae = a; nm = n;
        ok = e && !a && !n;
        ev = 1'b0; eg = '0; nh = 1'b0; np = m_ptr; tag = "R5";
        if (!m_hold) begin
            if (ok && r != 0) begin
                for (int k = 3; k >= 0; k--)
                    if (r[ch_at(m, m_ptr, k)]) eg = 4'(1 << ch_at(m, m_ptr, k));
                ev = 1'b1; nh = 1'b1;
                for (int c = 0; c < 4; c++) if (eg[c] && m == 2'b11) np = 2'(c + 1);
                tag = (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : (m == 2'b10) ? "R3" : "R4";
            end else begin
                tag = !e ? "R6" : (a || n) ? "R7" : "R9";
            end
        end else begin
            if (ok && (r & m_grant) != 0) begin
                eg = m_grant; nh = 1'b1; tag = "R8";
            end else begin
                tag = !e ? "R6" : (a || n) ? "R7" : "R9";
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(grant == eg && vld == ev, tag, {vld, grant}, {ev, eg});
        m_hold = nh; m_grant = eg; m_ptr = np;
    endtask

    task automatic release_all(input logic [1:0] m);
        step(4'b0000, m, 1'b1, 1'b0, 1'b0);
        step(4'b0000, m, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_hold = 1'b0; m_grant = '0; m_ptr = '0;
        repeat (3) @(negedge clk);
        check(grant == 4'b0000 && vld == 1'b0, "R10", {vld, grant}, 5'b0);
        rst_n = 1'b1;

        // R10: rotation starts at channel 0
        step(4'b1111, 2'b11, 1'b1, 1'b0, 1'b0);
        check(grant == 4'b0001, "R10", {vld, grant}, 5'b10001);
        release_all(2'b11);
        // R4: full rotation with wrap 3 -> 0
        for (int i = 0; i < 4; i++) begin
            step(4'b1111, 2'b11, 1'b1, 1'b0, 1'b0);
            release_all(2'b11);
        end
        step(4'b1001, 2'b11, 1'b1, 1'b0, 1'b0);
        release_all(2'b11);
        // R1, R2, R3: fixed orders with mixed request patterns
        for (int m = 0; m < 3; m++) begin
            step(4'b1111, 2'(m), 1'b1, 1'b0, 1'b0); release_all(2'(m));
            step(4'b1110, 2'(m), 1'b1, 1'b0, 1'b0); release_all(2'(m));
            step(4'b1010, 2'(m), 1'b1, 1'b0, 1'b0); release_all(2'(m));
            step(4'b1000, 2'(m), 1'b1, 1'b0, 1'b0); release_all(2'(m));
        end
        // R4: fixed-mode wins leave the rotation alone
        step(4'b1111, 2'b11, 1'b1, 1'b0, 1'b0); release_all(2'b11);
        // R8: mode and other requests change during a hold
        step(4'b0010, 2'b00, 1'b1, 1'b0, 1'b0);
        step(4'b1111, 2'b10, 1'b1, 1'b0, 1'b0);
        step(4'b0011, 2'b11, 1'b1, 1'b0, 1'b0);
        // R9: release, then idle gap before the next grant
        step(4'b0001, 2'b00, 1'b1, 1'b0, 1'b0);
        step(4'b0001, 2'b00, 1'b1, 1'b0, 1'b0);
        // R6, R7: blocking during hold and while idle
        step(4'b0001, 2'b00, 1'b0, 1'b0, 1'b0);
        step(4'b0001, 2'b00, 1'b0, 1'b0, 1'b0);
        step(4'b0001, 2'b00, 1'b1, 1'b0, 1'b0);
        step(4'b0001, 2'b00, 1'b1, 1'b1, 1'b0);
        step(4'b0001, 2'b00, 1'b1, 1'b0, 1'b1);
        step(4'b0001, 2'b00, 1'b1, 1'b0, 1'b0);
        step(4'b0001, 2'b00, 1'b1, 1'b0, 1'b1);
        release_all(2'b00);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] r;
            logic [1:0] m;
            r = 4'($urandom);
            if (m_hold && ($urandom % 4 != 0)) r = r | m_grant;
            m = md;
            if ($urandom % 16 == 0) m = 2'($urandom);
            step(r, m, ($urandom % 16) != 0, ($urandom % 32) == 0, ($urandom % 32) == 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule